// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Fill Flags

This block is a first-in first-out buffer whose write port and read port each have their own clock, and the two clocks need not be related. Words are 9 bits wide and the depth is a parameter. The write side accepts a word on each rising write-clock edge that its enables qualify. The read side moves one word into a registered output on each rising read-clock edge that its enables qualify. The output bus goes high-impedance while the output enable is high. Four active-low status flags report occupancy. Empty and almost-empty are produced in the read clock domain. Full and almost-full are produced in the write clock domain.

The second write-side pin has one of two roles, and the level on that pin during reset picks the role. If the pin is high during reset, it acts as a second write enable. If it is low during reset, it acts as a load strobe for two threshold offsets: the empty offset n and the full offset m. A small sequencer walks through four byte-wide slots in a fixed order: empty-low, empty-high, full-low, full-high, and then back to empty-low. It uses one sequencer for writing slots and a separate one for reading them back. Each offset is `$clog2(DEPTH)` bits wide. The low slot holds bits 7:0. The high slot holds the bits above bit 7 and takes them from the low bits of the byte written.

Pointers cross between the clock domains as Gray code through two-flop synchronizers. As a result, each flag can clear late but never early.

Top module: `dc_flag_fifo`

## Requirements
- R1: While `rst_n` is low, both pointers are cleared, `full_n` and `almost_full_n` are high, `empty_n` and `almost_empty_n` are low, and the output register is zero.
- R2: The level of `wr_en2_ld` sampled by each clock while reset is low sets the mode until the next reset: high gives dual-enable mode, low gives offset-load mode.
- R3: A word is stored on a rising `wclk` edge when `wr_en1_n` is low and `wr_en2_ld` is high, in either mode. A write attempted while `full_n` is low is dropped and does not change the stored words.
- R4: A word moves to the output register on a rising `rclk` edge only when both `rd_en1_n` and `rd_en2_n` are low. Otherwise the output register holds its value. A read while `empty_n` is low changes nothing. Words leave in the order they were written.
- R5: With occupancy w, `empty_n` is low exactly when w = 0, and `full_n` is low exactly when w = DEPTH.
- R6: `almost_empty_n` is low when w ≤ n, and `almost_full_n` is low when w ≥ DEPTH − m. Both offsets reset to 7.
- R7: In offset-load mode, each rising `wclk` edge with `wr_en2_ld` low and `wr_en1_n` low writes `wr_data` into the next slot. The slot order is empty-low, empty-high, full-low, full-high, and then the sequence wraps. These cycles never store a word in the FIFO.
- R8: In offset-load mode, each rising `rclk` edge with `wr_en2_ld` low and both read enables low loads the next slot, zero-extended, into the output register. This uses the same slot order as R7 with its own sequencer, and it never moves the read pointer.
- R9: In dual-enable mode, `wr_en2_ld` low blocks writes and gives no offset access. Reads are unaffected by that pin.
- R10: With `rd_oe_n` high, `rd_data` is high-impedance. With `rd_oe_n` low, it drives the output register.
- R11: At any ratio of the two clocks, flags that lag synchronization never allow overflow or underflow, and no word is lost, duplicated or reordered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_data | input | DW | Write data; bits 7:0 also feed offset slots |
| wr_en1_n | input | 1 | Primary write enable, active low |
| wr_en2_ld | input | 1 | Second write enable (high) or offset-load strobe (low), role set at reset |
| rd_en1_n | input | 1 | Read enable one, active low |
| rd_en2_n | input | 1 | Read enable two, active low |
| rd_oe_n | input | 1 | Output enable, active low |
| rd_data | output | DW | Registered read data, tri-stated by `rd_oe_n` |
| empty_n | output | 1 | Empty flag, active low, read domain |
| almost_empty_n | output | 1 | Almost-empty flag, active low, read domain |
| almost_full_n | output | 1 | Almost-full flag, active low, write domain |
| full_n | output | 1 | Full flag, active low, write domain |

## Verification
The cycle-level checks cover several invariants. A pointer never moves while its own domain's blocking flag is low, and it never moves during an offset-load cycle. Pointers advance by at most one per edge. Full implies almost-full and empty implies almost-empty. The mode stays fixed outside reset. Only the directed and random scenarios can show the following: the exact flag thresholds for default and reprogrammed offsets, the slot sequence and its wrap, and the role of the dual pin in each mode. They also show the tri-state output and the in-order, loss-free transfer of data while the read clock runs equal to, slower than and faster than the write clock.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
    // Offset slot visited by the load/readback sequencers; order is behaviour.
    typedef enum logic [1:0] {
        SL_EMPTY_LO = 2'd0,
        SL_EMPTY_HI = 2'd1,
        SL_FULL_LO  = 2'd2,
        SL_FULL_HI  = 2'd3
    } slot_e;
endpackage

// File: rtl/dcf_ptr_sync.sv
// Two-flop synchronizer for a Gray pointer, converted back to binary.
module dcf_ptr_sync #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] gray_i,
    output logic [W-1:0] bin_o
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= gray_i;
            stage2_q <= stage1_q;
        end
    end

    always_comb begin
        for (int i = 0; i < W; i++) begin
            bin_o[i] = ^(stage2_q >> i);
        end
    end
endmodule

// File: rtl/dcf_slot_seq.sv
// Four-state slot sequencer: EMPTY_LO -> EMPTY_HI -> FULL_LO -> FULL_HI -> EMPTY_LO.
module dcf_slot_seq
    import dcf_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  adv,
    output slot_e slot_o
);
    slot_e st_q;
    slot_e st_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= SL_EMPTY_LO;
        end else begin
            st_q <= st_nxt;
        end
    end

    always_comb begin
        st_nxt = st_q;
        unique case (st_q)
            SL_EMPTY_LO: if (adv) st_nxt = SL_EMPTY_HI;
            SL_EMPTY_HI: if (adv) st_nxt = SL_FULL_LO;
            SL_FULL_LO:  if (adv) st_nxt = SL_FULL_HI;
            SL_FULL_HI:  if (adv) st_nxt = SL_EMPTY_LO;
        endcase
    end

    always_comb begin
        slot_o = st_q;
    end
endmodule

// File: rtl/dcf_offset_bank.sv
// Threshold offsets: written from the write domain, read back in the read domain.
module dcf_offset_bank
    import dcf_pkg::*;
#(
    parameter int AW      = 11,
    parameter int DEF_OFS = 7
) (
    input  logic          wclk,
    input  logic          rclk,
    input  logic          rst_n,
    input  logic          wr_step,
    input  logic [7:0]    wr_byte,
    input  logic          rd_step,
    output logic [7:0]    rd_byte,
    output logic [AW-1:0] empty_ofs,
    output logic [AW-1:0] full_ofs
);
    localparam int HW = AW - 8;
    localparam logic [7:0]    DEF_LO = 8'(DEF_OFS);
    localparam logic [HW-1:0] DEF_HI = HW'(DEF_OFS >> 8);

    slot_e wsel;
    slot_e rsel;
    logic [7:0]    e_lo_q, f_lo_q;
    logic [HW-1:0] e_hi_q, f_hi_q;

    dcf_slot_seq i_wr_seq (.clk(wclk), .rst_n(rst_n), .adv(wr_step), .slot_o(wsel));
    dcf_slot_seq i_rd_seq (.clk(rclk), .rst_n(rst_n), .adv(rd_step), .slot_o(rsel));

    always_ff @(posedge wclk or negedge rst_n) begin
        if (!rst_n) begin
            e_lo_q <= DEF_LO;
            e_hi_q <= DEF_HI;
            f_lo_q <= DEF_LO;
            f_hi_q <= DEF_HI;
        end else if (wr_step) begin
            unique case (wsel)
                SL_EMPTY_LO: e_lo_q <= wr_byte;
                SL_EMPTY_HI: e_hi_q <= wr_byte[HW-1:0];
                SL_FULL_LO:  f_lo_q <= wr_byte;
                SL_FULL_HI:  f_hi_q <= wr_byte[HW-1:0];
            endcase
        end
    end

    always_comb begin
        unique case (rsel)
            SL_EMPTY_LO: rd_byte = e_lo_q;
            SL_EMPTY_HI: rd_byte = 8'(e_hi_q);
            SL_FULL_LO:  rd_byte = f_lo_q;
            SL_FULL_HI:  rd_byte = 8'(f_hi_q);
        endcase
    end

    assign empty_ofs = {e_hi_q, e_lo_q};
    assign full_ofs  = {f_hi_q, f_lo_q};
endmodule

// File: rtl/dc_flag_fifo.sv
module dc_flag_fifo #(
    parameter int DW      = 9,
    parameter int DEPTH   = 2048,
    parameter int DEF_OFS = 7
) (
    input  logic          wclk,
    input  logic          rclk,
    input  logic          rst_n,
    input  logic [DW-1:0] wr_data,
    input  logic          wr_en1_n,
    input  logic          wr_en2_ld,
    input  logic          rd_en1_n,
    input  logic          rd_en2_n,
    input  logic          rd_oe_n,
    output logic [DW-1:0] rd_data,
    output logic          empty_n,
    output logic          almost_empty_n,
    output logic          almost_full_n,
    output logic          full_n
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;
    localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

    logic [DW-1:0] mem [DEPTH];

    // ---------------- write domain ----------------
    logic          wr_prog_q;
    logic [PW-1:0] wbin_q, wgray_q, wbin_nxt, rsync_bin, wocc;
    logic          full_n_q, af_n_q;
    logic          wr_norm, wr_do, ofs_wr;
    logic [AW-1:0] empty_ofs, full_ofs;

    always_ff @(posedge wclk) begin
        if (!rst_n) wr_prog_q <= !wr_en2_ld;
    end

    assign wr_norm  = !wr_en1_n && wr_en2_ld;
    assign ofs_wr   = wr_prog_q && !wr_en2_ld && !wr_en1_n;
    assign wr_do    = wr_norm && full_n_q;
    assign wbin_nxt = wbin_q + PW'(wr_do);
    assign wocc     = wbin_nxt - rsync_bin;

    always_ff @(posedge wclk or negedge rst_n) begin
        if (!rst_n) begin
            wbin_q   <= '0;
            wgray_q  <= '0;
            full_n_q <= 1'b1;
            af_n_q   <= 1'b1;
        end else begin
            wbin_q   <= wbin_nxt;
            wgray_q  <= wbin_nxt ^ (wbin_nxt >> 1);
            full_n_q <= (wocc != DEPTH_P);
            af_n_q   <= (wocc < (DEPTH_P - {1'b0, full_ofs}));
        end
    end

    always_ff @(posedge wclk) begin
        if (wr_do) mem[wbin_q[AW-1:0]] <= wr_data;
    end

    // ---------------- read domain ----------------
    logic          rd_prog_q;
    logic [PW-1:0] rbin_q, rgray_q, rbin_nxt, wsync_bin, rocc;
    logic          empty_n_q, ae_n_q;
    logic          rd_both, rd_load, rd_do, ofs_rd;
    logic [DW-1:0] q_r;
    logic [7:0]    ofs_byte;

    always_ff @(posedge rclk) begin
        if (!rst_n) rd_prog_q <= !wr_en2_ld;
    end

    assign rd_both  = !rd_en1_n && !rd_en2_n;
    assign rd_load  = rd_prog_q && !wr_en2_ld;
    assign ofs_rd   = rd_load && rd_both;
    assign rd_do    = rd_both && !rd_load && empty_n_q;
    assign rbin_nxt = rbin_q + PW'(rd_do);
    assign rocc     = wsync_bin - rbin_nxt;

    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n) begin
            rbin_q    <= '0;
            rgray_q   <= '0;
            empty_n_q <= 1'b0;
            ae_n_q    <= 1'b0;
            q_r       <= '0;
        end else begin
            rbin_q    <= rbin_nxt;
            rgray_q   <= rbin_nxt ^ (rbin_nxt >> 1);
            empty_n_q <= (rocc != '0);
            ae_n_q    <= (rocc > {1'b0, empty_ofs});
            if (rd_do) begin
                q_r <= mem[rbin_q[AW-1:0]];
            end else if (ofs_rd) begin
                q_r <= DW'(ofs_byte);
            end
        end
    end

    // ---------------- crossings and offsets ----------------
    dcf_ptr_sync #(.W(PW)) i_w2r (.clk(rclk), .rst_n(rst_n), .gray_i(wgray_q), .bin_o(wsync_bin));
    dcf_ptr_sync #(.W(PW)) i_r2w (.clk(wclk), .rst_n(rst_n), .gray_i(rgray_q), .bin_o(rsync_bin));

    dcf_offset_bank #(.AW(AW), .DEF_OFS(DEF_OFS)) i_ofs (
        .wclk     (wclk),
        .rclk     (rclk),
        .rst_n    (rst_n),
        .wr_step  (ofs_wr),
        .wr_byte  (wr_data[7:0]),
        .rd_step  (ofs_rd),
        .rd_byte  (ofs_byte),
        .empty_ofs(empty_ofs),
        .full_ofs (full_ofs)
    );

    assign rd_data        = rd_oe_n ? {DW{1'bz}} : q_r;
    assign empty_n        = empty_n_q;
    assign almost_empty_n = ae_n_q;
    assign almost_full_n  = af_n_q;
    assign full_n         = full_n_q;
endmodule

// File: rtl/dcf_checker.sv
module dcf_checker #(
    parameter int DEPTH = 2048
) (
    input logic                      wclk,
    input logic                      rclk,
    input logic                      rst_n,
    input logic                      wr_prog,
    input logic                      ofs_wr,
    input logic                      ofs_rd,
    input logic [$clog2(DEPTH):0]    wbin,
    input logic [$clog2(DEPTH):0]    rbin,
    input logic                      empty_n,
    input logic                      almost_empty_n,
    input logic                      almost_full_n,
    input logic                      full_n
);
    a_r3_full_blocks_write: assert property (@(posedge wclk) disable iff (!rst_n)
        !full_n |=> wbin == $past(wbin));

    a_r4_empty_blocks_read: assert property (@(posedge rclk) disable iff (!rst_n)
        !empty_n |=> rbin == $past(rbin));

    a_r5_full_implies_af: assert property (@(posedge wclk) disable iff (!rst_n)
        !full_n |-> !almost_full_n);

    a_r5_empty_implies_ae: assert property (@(posedge rclk) disable iff (!rst_n)
        !empty_n |-> !almost_empty_n);

    a_r7_load_holds_wptr: assert property (@(posedge wclk) disable iff (!rst_n)
        ofs_wr |=> wbin == $past(wbin));

    a_r8_load_holds_rptr: assert property (@(posedge rclk) disable iff (!rst_n)
        ofs_rd |=> rbin == $past(rbin));

    a_r2_mode_steady: assert property (@(posedge wclk) disable iff (!rst_n)
        1'b1 |=> $stable(wr_prog));

    a_r11_wptr_unit_step: assert property (@(posedge wclk) disable iff (!rst_n)
        (wbin == $past(wbin)) || (wbin == $past(wbin) + 1'b1));

    a_r11_rptr_unit_step: assert property (@(posedge rclk) disable iff (!rst_n)
        (rbin == $past(rbin)) || (rbin == $past(rbin) + 1'b1));
endmodule

bind dc_flag_fifo dcf_checker #(.DEPTH(DEPTH)) u_dcf_checker (
    .wclk          (wclk),
    .rclk          (rclk),
    .rst_n         (rst_n),
    .wr_prog       (wr_prog_q),
    .ofs_wr        (ofs_wr),
    .ofs_rd        (ofs_rd),
    .wbin          (wbin_q),
    .rbin          (rbin_q),
    .empty_n       (empty_n),
    .almost_empty_n(almost_empty_n),
    .almost_full_n (almost_full_n),
    .full_n        (full_n)
);

// File: tb/test_dc_flag_fifo.sv
`timescale 1ns/1ps
module test_dc_flag_fifo;
    localparam int DW    = 9;
    localparam int DEPTH = 512;

    logic wclk = 1'b0;
    logic rclk = 1'b0;
    real  rhalf = 2.0;
    always #2 wclk = ~wclk;
    always #(rhalf) rclk = ~rclk;

    logic          rst_n = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          wr_en1_n = 1'b1, wr_en2_ld = 1'b1;
    logic          rd_en1_n = 1'b1, rd_en2_n = 1'b1, rd_oe_n = 1'b0;
    wire  [DW-1:0] rd_data;
    logic          empty_n, almost_empty_n, almost_full_n, full_n;

    for (genvar i = 0; i < DW; i++) begin : g_pu
        pullup (rd_data[i]);
    end

    dc_flag_fifo #(.DW(DW), .DEPTH(DEPTH), .DEF_OFS(7)) i_dc_flag_fifo (
        .wclk(wclk), .rclk(rclk), .rst_n(rst_n),
        .wr_data(wr_data), .wr_en1_n(wr_en1_n), .wr_en2_ld(wr_en2_ld),
        .rd_en1_n(rd_en1_n), .rd_en2_n(rd_en2_n), .rd_oe_n(rd_oe_n),
        .rd_data(rd_data), .empty_n(empty_n), .almost_empty_n(almost_empty_n),
        .almost_full_n(almost_full_n), .full_n(full_n)
    );

    int unsigned   checks = 0;
    int unsigned   fails  = 0;
    logic [DW-1:0] model_q [$];
    logic [DW-1:0] last_rd = '0;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int exp_ae(input int w, input int n); return (w > n) ? 1 : 0; endfunction
    function automatic int exp_af(input int w, input int m); return (w < DEPTH - m) ? 1 : 0; endfunction

    task automatic chk_flags(input int w, input int n, input int m);
        check("R5 empty_n", empty_n, (w != 0) ? 1 : 0);
        check("R5 full_n", full_n, (w != DEPTH) ? 1 : 0);
        check("R6 almost_empty_n", almost_empty_n, exp_ae(w, n));
        check("R6 almost_full_n", almost_full_n, exp_af(w, m));
    endtask

    task automatic settle();
        repeat (8) @(negedge wclk);
        repeat (8) @(negedge rclk);
    endtask

    task automatic do_reset(input logic ld_level);
        @(negedge wclk);
        rst_n = 1'b0; wr_en2_ld = ld_level; wr_en1_n = 1'b1;
        rd_en1_n = 1'b1; rd_en2_n = 1'b1;
        repeat (4) @(negedge wclk);
        repeat (4) @(negedge rclk);
        @(negedge wclk);
        rst_n = 1'b1; wr_en2_ld = 1'b1;
        model_q.delete();
        repeat (3) @(negedge wclk);
        repeat (3) @(negedge rclk);
    endtask

    task automatic put_n(input int count, input int base);
        for (int k = 0; k < count; k++) begin
            @(negedge wclk);
            wr_data = DW'(base + k * 37);
            wr_en1_n = 1'b0;
            if (full_n) model_q.push_back(wr_data);
        end
        @(negedge wclk);
        wr_en1_n = 1'b1;
    endtask

    task automatic get_n(input int count, input string req);
        bit pend = 1'b0;
        logic [DW-1:0] e = '0;
        for (int k = 0; k < count; k++) begin
            @(negedge rclk);
            if (pend) begin check(req, rd_data, e); last_rd = e; end
            rd_en1_n = 1'b0; rd_en2_n = 1'b0;
            pend = empty_n;
            if (pend) begin
                if (model_q.size() == 0) begin
                    check("R11 underflow", 1, 0);
                    pend = 1'b0;
                end else begin
                    e = model_q.pop_front();
                end
            end
        end
        @(negedge rclk);
        rd_en1_n = 1'b1; rd_en2_n = 1'b1;
        if (pend) begin check(req, rd_data, e); last_rd = e; end
    endtask

    task automatic ofs_write(input logic [7:0] b);
        @(negedge wclk);
        wr_en2_ld = 1'b0; wr_en1_n = 1'b0; wr_data = DW'(b);
        @(negedge wclk);
        wr_en1_n = 1'b1; wr_en2_ld = 1'b1;
    endtask

    task automatic ofs_read(input int exp, input string req);
        @(negedge rclk);
        wr_en2_ld = 1'b0; rd_en1_n = 1'b0; rd_en2_n = 1'b0;
        @(negedge rclk);
        rd_en1_n = 1'b1; rd_en2_n = 1'b1; wr_en2_ld = 1'b1;
        check(req, rd_data, exp);
    endtask

    task automatic random_round(input real half, input int wp, input int rp);
        rhalf = half;
        fork
            begin
                for (int k = 0; k < 1500; k++) begin
                    @(negedge wclk);
                    wr_en1_n  = !(($urandom % 100) < wp);
                    wr_en2_ld = (($urandom % 10) != 0);
                    wr_data   = DW'($urandom);
                    if (full_n) check("R11 overflow", (model_q.size() >= DEPTH) ? 1 : 0, 0);
                    if (!wr_en1_n && wr_en2_ld && full_n) model_q.push_back(wr_data);
                end
                @(negedge wclk);
                wr_en1_n = 1'b1; wr_en2_ld = 1'b1;
            end
            begin
                bit pend = 1'b0;
                logic [DW-1:0] e = '0;
                int rc = int'(1500.0 * 2.0 / half) + 40;
                for (int k = 0; k < rc; k++) begin
                    @(negedge rclk);
                    if (pend) check("R11 order", rd_data, e);
                    rd_en1_n = !(($urandom % 100) < rp);
                    rd_en2_n = !(($urandom % 100) < 85);
                    pend = !rd_en1_n && !rd_en2_n && empty_n;
                    if (pend) begin
                        if (model_q.size() == 0) begin check("R11 underflow", 1, 0); pend = 1'b0; end
                        else e = model_q.pop_front();
                    end
                end
                @(negedge rclk);
                rd_en1_n = 1'b1; rd_en2_n = 1'b1;
                if (pend) check("R11 order", rd_data, e);
            end
        join
        settle();
        get_n(DEPTH + 4, "R11 drain");
        settle();
        check("R11 model drained", model_q.size(), 0);
        check("R11 empty after drain", empty_n, 0);
    endtask

    initial begin
        #800000;
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_C0DE));
        // R1, R2: reset into offset-load mode
        do_reset(1'b0);
        check("R1 full_n", full_n, 1);
        check("R1 almost_full_n", almost_full_n, 1);
        check("R1 empty_n", empty_n, 0);
        check("R1 almost_empty_n", almost_empty_n, 0);
        check("R1 output register", rd_data, 0);
        // R10: tri-state via pulled-up bus
        rd_oe_n = 1'b1; #1;
        check("R10 high-z", rd_data, 9'h1FF);
        rd_oe_n = 1'b0; #1;
        check("R10 driven", rd_data, 0);
        // R8, R6: default offsets read back
        ofs_read(7, "R8 slot empty-low");
        ofs_read(0, "R8 slot empty-high");
        ofs_read(7, "R8 slot full-low");
        ofs_read(0, "R8 slot full-high");
        // R5, R6 with default offsets
        put_n(7, 5);   settle(); chk_flags(7, 7, 7);
        put_n(1, 90);  settle(); chk_flags(8, 7, 7);
        put_n(496, 11); settle(); chk_flags(504, 7, 7);
        put_n(1, 200); settle(); chk_flags(505, 7, 7);
        put_n(7, 300); settle(); chk_flags(512, 7, 7);
        // R3: write while full is dropped (verified by drain order)
        put_n(1, 9'h0AA);
        // R4: only one read enable low holds output
        @(negedge rclk); rd_en1_n = 1'b0; rd_en2_n = 1'b1;
        @(negedge rclk); rd_en1_n = 1'b1;
        check("R4 hold with one enable", rd_data, 0);
        get_n(DEPTH, "R4 in-order");
        settle();
        chk_flags(0, 7, 7);
        get_n(1, "R4 empty read");
        check("R4 empty read holds", rd_data, last_rd);
        // R7: program offsets, fifth write wraps to empty-low
        ofs_write(8'd3); ofs_write(8'd0); ofs_write(8'd1); ofs_write(8'd1); ofs_write(8'd2);
        ofs_read(2, "R7 wrap empty-low");
        ofs_read(0, "R7 empty-high");
        ofs_read(1, "R7 full-low");
        ofs_read(1, "R7 full-high");
        settle();
        check("R7 fifo untouched", empty_n, 0);
        // R6 with n=2, m=257
        put_n(2, 17);   settle(); chk_flags(2, 2, 257);
        put_n(1, 41);   settle(); chk_flags(3, 2, 257);
        put_n(251, 63); settle(); chk_flags(254, 2, 257);
        put_n(1, 77);   settle(); chk_flags(255, 2, 257);
        get_n(255, "R4 in-order programmed");
        // R9, R2: dual-enable mode
        do_reset(1'b1);
        @(negedge wclk); wr_en2_ld = 1'b0; wr_en1_n = 1'b0; wr_data = 9'h1C3;
        repeat (3) @(negedge wclk);
        wr_en1_n = 1'b1; wr_en2_ld = 1'b1;
        settle();
        check("R9 second enable blocks write", empty_n, 0);
        put_n(1, 9'h155); settle();
        wr_en2_ld = 1'b0;
        get_n(1, "R9 read ignores pin");
        wr_en2_ld = 1'b1;
        check("R9 word read", last_rd, 9'h155);
        // R11: random traffic at several clock ratios
        random_round(2.0, 70, 60);
        random_round(3.3, 60, 80);
        random_round(7.1, 85, 90);
        random_round(1.3, 80, 40);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule